// File: doc/BRIEF.md
# Test Mode Selector and Test Bus Multiplexer

This block places a chip into its normal operating mode or into one of three test modes. Two dedicated test pins carry a 2-bit mode code. Each test mode gives one of three logic partitions sole use of the chip pins. The block stops the other two partitions by dropping their clock enables. Partition clocks are gated outside this block. The enables change only on a rising clock edge, so a gated clock never sees a runt pulse.

Sixteen output pins are shared between functional values and a 16-bit test bus. The test bus is built from a chain of three 2:1 multiplexer stages, one stage per test mode. Each stage replaces the value from the stage before it with the observation group of its own partition when that partition's mode is active. At any time exactly one source drives each pin. Eleven input pins are shared the same way. In normal mode they feed the functional core. In a test mode they fan out to the test points of the active partition only.

The pins that are not shared bypass this block. The mode code passes through a two-stage synchronizer and then a mode register. The mode state machine has four states: NORMAL, TEST_P1, TEST_P2 and TEST_P3. It makes these named transitions:
- ENTER_TEST: NORMAL to TEST_Pk on code k.
- LEAVE_TEST: TEST_Pk to NORMAL on code 00.
- SWITCH_TEST: TEST_Pj to TEST_Pk directly.
- HOLD: the state stays when the code matches it.

Top module: `test_mode_ctrl`

## Requirements
- R1: While reset is asserted, the mode is normal, `part_clk_en` is 3'b111 and `pad_out` equals `func_out`.
- R2: The mode code is 2'b00 for normal, 2'b01 for partition 1, 2'b10 for partition 2 and 2'b11 for partition 3. A new code on `test_sel` takes effect at the third rising edge after it is applied, and not before.
- R3: In normal mode:
  - `part_clk_en` is 3'b111.
  - `pad_out` equals `func_out`.
  - `core_in` equals `pad_in`.
  - All three test point buses are zero.
- R4: In test mode k, only clock enable bit k-1 is set. Bit 0 belongs to partition 1, bit 1 to partition 2 and bit 2 to partition 3.
- R5: In test mode k, `pad_out` equals the observation group of partition k. `func_out` and the other two observation groups have no effect on `pad_out`.
- R6: In test mode k:
  - The test point bus of partition k equals `pad_in`.
  - `core_in` is zero.
  - The other two test point buses are zero.
- R7: `part_clk_en` changes only at a rising clock edge, at the same edge as the mode. A change on `test_sel` between edges leaves it unchanged.
- R8: When switching directly between two test modes, no cycle ever has more than one clock enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_sel | input | 2 | Mode code from the two test pins |
| func_out | input | 16 | Functional values for the shared output pins |
| p1_obs | input | 16 | Observation group of partition 1 |
| p2_obs | input | 16 | Observation group of partition 2 |
| p3_obs | input | 16 | Observation group of partition 3 |
| pad_out | output | 16 | Shared output pins |
| pad_in | input | 11 | Shared input pins |
| core_in | output | 11 | Shared inputs delivered to the functional core |
| p1_tp | output | 11 | Test points of partition 1 |
| p2_tp | output | 11 | Test points of partition 2 |
| p3_tp | output | 11 | Test points of partition 3 |
| part_clk_en | output | 3 | Clock enables of partitions 3..1 |

## Verification
The hardest situation to reach is a direct switch from one test mode to another. In that case a badly ordered enable update could run two partitions in the same cycle, or could route an unselected group for one cycle. The stimulus draws long random sequences of mode codes, so many transitions go from test mode to test mode without passing through normal. It checks the enable count at every cycle of each switch. While a mode is held, every observation group, `func_out` and `pad_in` is randomized on every cycle. This shows that only the selected source ever reaches a pin.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    localparam int NUM_PART = 3;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_P1     = 2'b01,
        MODE_P2     = 2'b10,
        MODE_P3     = 2'b11
    } tmode_e;

    // Clock enable pattern for a mode: all on in normal, one-hot in test.
    function automatic logic [NUM_PART-1:0] part_enables(input tmode_e m);
        logic [NUM_PART-1:0] en;
        unique case (m)
            MODE_NORMAL: en = '1;
            MODE_P1:     en = 3'b001;
            MODE_P2:     en = 3'b010;
            MODE_P3:     en = 3'b100;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/tmc_pin_sync.sv
module tmc_pin_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tmc_mode_fsm.sv
module tmc_mode_fsm
    import tmc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          sel_sync,
    output tmode_e              mode,
    output logic [NUM_PART-1:0] clk_en
);
    tmode_e              state_q, state_d;
    tmode_e              code;
    logic [NUM_PART-1:0] en_q;

    assign code = tmode_e'(sel_sync);

    // Transitions: ENTER_TEST, LEAVE_TEST, SWITCH_TEST, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL: if (code != MODE_NORMAL) state_d = code;   // ENTER_TEST
            MODE_P1, MODE_P2, MODE_P3: begin
                if (code == MODE_NORMAL)  state_d = MODE_NORMAL;    // LEAVE_TEST
                else if (code != state_q) state_d = code;           // SWITCH_TEST
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_NORMAL;
        else        state_q <= state_d;
    end

    // Output register: enables move on the same edge as the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '1;
        else        en_q <= part_enables(state_d);
    end

    assign mode   = state_q;
    assign clk_en = en_q;

    a_r3_all_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_NORMAL) |-> (en_q == 3'b111));
    a_r4_single_partition: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MODE_NORMAL) |-> ($countones(en_q) == 1));
    a_r7_enable_with_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) |-> !$stable(state_q));
endmodule

// File: rtl/tmc_obs_chain.sv
module tmc_obs_chain
    import tmc_pkg::*;
#(
    parameter int W = 16
) (
    input  tmode_e       mode,
    input  logic [W-1:0] func_val,
    input  logic [W-1:0] obs [NUM_PART],
    output logic [W-1:0] bus_out
);
    logic [W-1:0] stage [NUM_PART+1];

    assign stage[0] = func_val;

    // One 2:1 stage per test mode; stage k claims the bus in mode k+1
    for (genvar k = 0; k < NUM_PART; k++) begin : g_mux
        assign stage[k+1] = (mode == tmode_e'(2'(k + 1))) ? obs[k] : stage[k];
    end

    assign bus_out = stage[NUM_PART];
endmodule

// File: rtl/tmc_in_steer.sv
module tmc_in_steer
    import tmc_pkg::*;
#(
    parameter int W = 11
) (
    input  tmode_e       mode,
    input  logic [W-1:0] pins,
    output logic [W-1:0] core_val,
    output logic [W-1:0] tp [NUM_PART]
);
    assign core_val = (mode == MODE_NORMAL) ? pins : '0;

    for (genvar k = 0; k < NUM_PART; k++) begin : g_tp
        assign tp[k] = (mode == tmode_e'(2'(k + 1))) ? pins : '0;
    end
endmodule

// File: rtl/test_mode_ctrl.sv
module test_mode_ctrl
    import tmc_pkg::*;
#(
    parameter int OUT_W       = 16,
    parameter int IN_W        = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       test_sel,
    input  logic [OUT_W-1:0] func_out,
    input  logic [OUT_W-1:0] p1_obs,
    input  logic [OUT_W-1:0] p2_obs,
    input  logic [OUT_W-1:0] p3_obs,
    output logic [OUT_W-1:0] pad_out,
    input  logic [IN_W-1:0]  pad_in,
    output logic [IN_W-1:0]  core_in,
    output logic [IN_W-1:0]  p1_tp,
    output logic [IN_W-1:0]  p2_tp,
    output logic [IN_W-1:0]  p3_tp,
    output logic [2:0]       part_clk_en
);
    logic [1:0]       sel_sync;
    tmode_e           mode;
    logic [OUT_W-1:0] obs_grp [NUM_PART];
    logic [IN_W-1:0]  tp_grp  [NUM_PART];

    tmc_pin_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (test_sel),
        .q     (sel_sync)
    );

    tmc_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_sync (sel_sync),
        .mode     (mode),
        .clk_en   (part_clk_en)
    );

    assign obs_grp[0] = p1_obs;
    assign obs_grp[1] = p2_obs;
    assign obs_grp[2] = p3_obs;

    tmc_obs_chain #(.W(OUT_W)) u_chain (
        .mode     (mode),
        .func_val (func_out),
        .obs      (obs_grp),
        .bus_out  (pad_out)
    );

    tmc_in_steer #(.W(IN_W)) u_steer (
        .mode     (mode),
        .pins     (pad_in),
        .core_val (core_in),
        .tp       (tp_grp)
    );

    assign p1_tp = tp_grp[0];
    assign p2_tp = tp_grp[1];
    assign p3_tp = tp_grp[2];

    a_r3_normal_route: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL) |-> (pad_out == func_out && core_in == pad_in));
    a_r5_p1_route: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_P1) |-> (pad_out == p1_obs));
    a_r5_p2_route: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_P2) |-> (pad_out == p2_obs));
    a_r5_p3_route: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_P3) |-> (pad_out == p3_obs));
    a_r6_one_input_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|core_in, |p1_tp, |p2_tp, |p3_tp}));
    a_r8_no_double_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_NORMAL) |=> (mode == MODE_NORMAL || $countones(part_clk_en) == 1));
endmodule

// File: tb/tb_test_mode_ctrl.sv
`timescale 1ns/1ps
module tb_test_mode_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  test_sel = 0;
    logic [15:0] func_out = 0, p1_obs = 0, p2_obs = 0, p3_obs = 0;
    logic [15:0] pad_out;
    logic [10:0] pad_in = 0;
    logic [10:0] core_in, p1_tp, p2_tp, p3_tp;
    logic [2:0]  part_clk_en;

    int total = 0;
    int bad   = 0;
    int cur   = 0;

    always #10 clk = ~clk;

    test_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .test_sel(test_sel),
        .func_out(func_out), .p1_obs(p1_obs), .p2_obs(p2_obs), .p3_obs(p3_obs),
        .pad_out(pad_out), .pad_in(pad_in), .core_in(core_in),
        .p1_tp(p1_tp), .p2_tp(p2_tp), .p3_tp(p3_tp), .part_clk_en(part_clk_en)
    );

    function automatic logic [2:0] exp_en(input int m);
        return (m == 0) ? 3'b111 : 3'(1 << (m - 1));
    endfunction

    function automatic logic [15:0] exp_out(input int m);
        case (m)
            1: return p1_obs;
            2: return p2_obs;
            3: return p3_obs;
            default: return func_out;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic check_all(input int m);
        check(part_clk_en == exp_en(m), (m == 0) ? "R3 enables" : "R4 enables",
              32'(part_clk_en), 32'(exp_en(m)));
        check(pad_out == exp_out(m), (m == 0) ? "R3 pad_out" : "R5 pad_out",
              32'(pad_out), 32'(exp_out(m)));
        check(core_in == ((m == 0) ? pad_in : 11'd0), "R3/R6 core_in",
              32'(core_in), 32'((m == 0) ? pad_in : 11'd0));
        check(p1_tp == ((m == 1) ? pad_in : 11'd0), "R6 p1_tp",
              32'(p1_tp), 32'((m == 1) ? pad_in : 11'd0));
        check(p2_tp == ((m == 2) ? pad_in : 11'd0), "R6 p2_tp",
              32'(p2_tp), 32'((m == 2) ? pad_in : 11'd0));
        check(p3_tp == ((m == 3) ? pad_in : 11'd0), "R6 p3_tp",
              32'(p3_tp), 32'((m == 3) ? pad_in : 11'd0));
    endtask

    task automatic randomize_pins();
        func_out = 16'($urandom);
        p1_obs   = 16'($urandom);
        p2_obs   = 16'($urandom);
        p3_obs   = 16'($urandom);
        pad_in   = 11'($urandom);
    endtask

    // Apply a mode code and track the three-edge latency (R2, R7, R8)
    task automatic set_mode(input int m);
        @(negedge clk);
        test_sel = 2'(m);
        #1;
        check(part_clk_en == exp_en(cur), "R7 no change between edges",
              32'(part_clk_en), 32'(exp_en(cur)));
        for (int e = 1; e <= 3; e++) begin
            @(posedge clk);
            @(negedge clk);
            check($countones(part_clk_en) <= 1 || part_clk_en == 3'b111,
                  "R8 at most one enable", 32'(part_clk_en), 32'(exp_en(m)));
            if (e < 3)
                check(part_clk_en == exp_en(cur), "R2 not before third edge",
                      32'(part_clk_en), 32'(exp_en(cur)));
        end
        cur = m;
        check(part_clk_en == exp_en(m), "R2 mode after third edge",
              32'(part_clk_en), 32'(exp_en(m)));
    endtask

    task automatic exercise(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            randomize_pins();
            #1;
            check_all(cur);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        logic [15:0] held;
        seed_dummy = $urandom(32'd4401);
        randomize_pins();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(part_clk_en == 3'b111, "R1 reset enables", 32'(part_clk_en), 32'h7);
        check(pad_out == func_out, "R1 reset pad_out", 32'(pad_out), 32'(func_out));
        rst_n = 1;
        exercise(4);

        // Directed: each mode from normal, then direct test-to-test switches
        set_mode(1); exercise(4);
        set_mode(0); exercise(4);
        set_mode(2); exercise(4);
        set_mode(3); exercise(4);
        set_mode(1); exercise(4);
        set_mode(2); exercise(4);

        // R5: in mode 2, the unselected sources do not move pad_out
        held = p2_obs;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            func_out = 16'($urandom);
            p1_obs   = 16'($urandom);
            p3_obs   = 16'($urandom);
            #1;
            check(pad_out == held, "R5 unselected ignored", 32'(pad_out), 32'(held));
        end

        // R7: a code that flips and returns between edges changes nothing
        @(negedge clk);
        test_sel = 2'd3;
        #3;
        test_sel = 2'd2;
        #1;
        check(part_clk_en == exp_en(2), "R7 glitch between edges",
              32'(part_clk_en), 32'(exp_en(2)));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(part_clk_en == exp_en(2), "R7 mode kept", 32'(part_clk_en), 32'(exp_en(2)));

        // Random mode sequences
        for (int r = 0; r < 60; r++) begin
            set_mode(int'($urandom_range(3, 0)));
            exercise(6);
        end

        set_mode(0);
        exercise(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule